// File: doc/BRIEF.md
# Flash Update Command Sequencer

This block carries out a host-driven rewrite of one of two serial flash devices. The host writes a small set of registers. It switches the block into update mode, picks a target device and an operation, and stages an image block in a shared byte buffer. It then gives the block number and raises a trigger. The sequencer either issues a whole-chip erase or streams one block of staged bytes to the flash program port. Each beat on that port is moved with a valid/ready handshake.

The two devices have different block sizes. A block is eight pages in both cases. Device A uses 528-byte pages, giving 4224-byte blocks. Device B uses 512-byte pages, giving 4096-byte blocks. Staged data is already byte-swapped within each 16-bit halfword, and the sequencer sends it in buffer order without undoing that swap. The block holds a busy flag for the whole operation and raises a one-cycle interrupt when the last beat has been accepted.

Top module: `flash_upd_seq`

## Requirements
- R1: After reset, busy_o, irq_o, upd_mode_o and fl_valid_o are all 0.
- R2: A write to offset 0x5C sets update mode when bit 0 is 1 and clears it when bit 0 is 0. upd_mode_o shows the new value from the cycle after the write.
- R3: Outside update mode a trigger is ignored: busy_o stays 0 and no flash beat is issued.
- R4: An operation starts only when a write to the trigger register (offset 0x6C, bit 0) changes the stored trigger bit from 0 to 1. Writing 1 again while it already holds 1 starts nothing.
- R5: The mode register at offset 0x58 selects the operation: bit 1 selects the device (0 = A, 1 = B), and bit 0 selects the operation (0 = chip erase, 1 = block program). Its value is captured when the operation starts.
- R6: A chip erase issues exactly one beat, with fl_prog_o = 0, fl_dev_o equal to the selected device and fl_addr_o = 0.
- R7: A block program issues exactly one block length of beats (4224 on A, 4096 on B) with fl_prog_o = 1. The beat addresses start at block_number × block length and rise by 1 per beat.
- R8: Beat i of a program reads the staging buffer at byte address 24576 + i and sends that byte unmodified on fl_data_o.
- R9: busy_o is 1 from the cycle after the starting trigger write until the cycle after the last beat is accepted. In that cycle irq_o pulses high for exactly one cycle and busy_o is 0.
- R10: Trigger writes while busy_o is 1 are ignored, including a 0-then-1 toggle. The operation still completes with its normal beat count and a single interrupt.
- R11: Clearing update mode while busy takes effect only when the operation completes. upd_mode_o stays 1 during the operation and reads 0 in the completion cycle.
- R12: While fl_valid_o is high and fl_ready_i is low, fl_valid_o, fl_addr_o and fl_prog_o hold their values on the next cycle.
- R13: The block number register is at offset 0x64 and is 16 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| busy_o | output | 1 | Operation in progress |
| irq_o | output | 1 | One-cycle completion interrupt |
| upd_mode_o | output | 1 | Update mode active |
| buf_addr_o | output | 15 | Staging buffer byte address |
| buf_rdata_i | input | 8 | Staging buffer byte at buf_addr_o (same cycle) |
| fl_valid_o | output | 1 | Flash beat valid |
| fl_ready_i | input | 1 | Flash port accepts beat |
| fl_prog_o | output | 1 | 1 = program byte, 0 = chip erase |
| fl_dev_o | output | 1 | Target device (0 = A, 1 = B) |
| fl_addr_o | output | 32 | Flash byte address |
| fl_data_o | output | 8 | Program byte |

## Verification
The hardest case to reach is register traffic that lands in the middle of a long program burst. This covers a trigger toggled from 0 to 1 and an update-mode clear, both arriving while thousands of beats remain. The bench reaches it by slowing the flash port with a pseudo-random ready pattern. It then issues those writes a fixed number of cycles into a device-B program, and afterwards checks the beat count, the single interrupt, and that update mode falls exactly at completion. The same ready pattern also creates many stalled beats, and the bench checks that the address holds still through each stall.

// File: rtl/fus_pkg.sv
package fus_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG} st_e;

  // bit1 = device, bit0 = program (1) / erase (0)
  typedef struct packed {
    logic dev;
    logic prog;
  } fmode_t;
endpackage

// File: rtl/fus_regs.sv
module fus_regs
  import fus_pkg::*;
#(
  parameter int REG_AW   = 7,
  parameter int BLK_W    = 16,
  parameter int MODE_OFS = 'h5C,
  parameter int FSEL_OFS = 'h58,
  parameter int BLK_OFS  = 'h64,
  parameter int TRIG_OFS = 'h6C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [BLK_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              mode_o,
  output fmode_t            fmode_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic              start_o
);
  logic   mode_q, exit_pend_q, trig_q;
  fmode_t fmode_q;
  logic [BLK_W-1:0] blk_q;

  logic mode_wr, fsel_wr, blk_wr, trig_wr;
  assign mode_wr = we_i && (addr_i == REG_AW'(MODE_OFS));
  assign fsel_wr = we_i && (addr_i == REG_AW'(FSEL_OFS));
  assign blk_wr  = we_i && (addr_i == REG_AW'(BLK_OFS));
  assign trig_wr = we_i && (addr_i == REG_AW'(TRIG_OFS));

  // rising edge of the stored trigger bit, only when idle and in update mode
  assign start_o = trig_wr && wdata_i[0] && !trig_q && mode_q && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 1'b0;
      exit_pend_q <= 1'b0;
      trig_q      <= 1'b0;
      fmode_q     <= '0;
      blk_q       <= '0;
    end else begin
      if (trig_wr) trig_q <= wdata_i[0];
      if (fsel_wr) fmode_q <= fmode_t'(wdata_i[1:0]);
      if (blk_wr)  blk_q <= wdata_i;
      if (mode_wr) begin
        if (wdata_i[0]) begin
          mode_q      <= 1'b1;
          exit_pend_q <= 1'b0;
        end else if (busy_i && !done_i) begin
          exit_pend_q <= 1'b1;
        end else begin
          mode_q      <= 1'b0;
          exit_pend_q <= 1'b0;
        end
      end else if (done_i && exit_pend_q) begin
        mode_q      <= 1'b0;
        exit_pend_q <= 1'b0;
      end
    end
  end

  assign mode_o  = mode_q;
  assign fmode_o = fmode_q;
  assign blk_o   = blk_q;

  // R11
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i && mode_q |=> mode_q);
endmodule

// File: rtl/fus_geom.sv
module fus_geom #(
  parameter int BLK_W  = 16,
  parameter int LEN_W  = 13,
  parameter int FL_AW  = 32,
  parameter int BLK_A  = 4224,
  parameter int BLK_B  = 4096
) (
  input  logic             dev_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [LEN_W-1:0] len_o,
  output logic [FL_AW-1:0] base_o
);
  assign len_o  = dev_i ? LEN_W'(BLK_B) : LEN_W'(BLK_A);
  assign base_o = FL_AW'(blk_i) * FL_AW'(len_o);
endmodule

// File: rtl/fus_stream.sv
module fus_stream
  import fus_pkg::*;
#(
  parameter int LEN_W      = 13,
  parameter int FL_AW      = 32,
  parameter int BUF_AW     = 15,
  parameter int STAGE_BASE = 24576
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              prog_i,
  input  logic              dev_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [FL_AW-1:0]  base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              fl_valid_o,
  input  logic              fl_ready_i,
  output logic              fl_prog_o,
  output logic              fl_dev_o,
  output logic [FL_AW-1:0]  fl_addr_o,
  output logic [7:0]        fl_data_o
);
  st_e              st_q;
  logic             dev_q, irq_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [FL_AW-1:0] base_q;
  logic             hs;

  assign fl_valid_o = (st_q != ST_IDLE);
  assign fl_prog_o  = (st_q == ST_PROG);
  assign fl_dev_o   = dev_q;
  assign fl_addr_o  = fl_prog_o ? base_q + FL_AW'(cnt_q) : '0;
  assign fl_data_o  = fl_prog_o ? buf_rdata_i : 8'h00;
  assign buf_addr_o = BUF_AW'(STAGE_BASE) + BUF_AW'(cnt_q);
  assign busy_o     = fl_valid_o;
  assign irq_o      = irq_q;

  assign hs     = fl_valid_o && fl_ready_i;
  assign done_o = hs && ((st_q == ST_ERASE) || (cnt_q == len_q - LEN_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dev_q  <= 1'b0;
      len_q  <= '0;
      cnt_q  <= '0;
      base_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= done_o;
      if (start_i) begin
        st_q   <= prog_i ? ST_PROG : ST_ERASE;
        dev_q  <= dev_i;
        len_q  <= len_i;
        base_q <= base_i;
        cnt_q  <= '0;
      end else if (done_o) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else if (hs) begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  // R12
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_valid_o && !fl_ready_i |=> fl_valid_o && $stable(fl_addr_o) && $stable(fl_prog_o));
  // R10
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> st_q == ST_IDLE);
  // R9
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o);
  // R9
  busy_fall_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_o);
endmodule

// File: rtl/flash_upd_seq.sv
module flash_upd_seq
  import fus_pkg::*;
#(
  parameter int REG_AW        = 7,
  parameter int BLK_W         = 16,
  parameter int PAGE_A        = 528,
  parameter int PAGE_B        = 512,
  parameter int PAGES_PER_BLK = 8,
  parameter int BUF_AW        = 15,
  parameter int STAGE_BASE    = 24576,
  parameter int FL_AW         = 32,
  parameter int MODE_OFS      = 'h5C,
  parameter int FSEL_OFS      = 'h58,
  parameter int BLK_OFS       = 'h64,
  parameter int TRIG_OFS      = 'h6C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [BLK_W-1:0]  reg_wdata_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              upd_mode_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              fl_valid_o,
  input  logic              fl_ready_i,
  output logic              fl_prog_o,
  output logic              fl_dev_o,
  output logic [FL_AW-1:0]  fl_addr_o,
  output logic [7:0]        fl_data_o
);
  localparam int BLK_A   = PAGE_A * PAGES_PER_BLK;
  localparam int BLK_B   = PAGE_B * PAGES_PER_BLK;
  localparam int BLK_MAX = (BLK_A > BLK_B) ? BLK_A : BLK_B;
  localparam int LEN_W   = $clog2(BLK_MAX + 1);

  fmode_t           fmode;
  logic [BLK_W-1:0] blk;
  logic             start, done;
  logic [LEN_W-1:0] len;
  logic [FL_AW-1:0] base;

  fus_regs #(
    .REG_AW(REG_AW), .BLK_W(BLK_W), .MODE_OFS(MODE_OFS),
    .FSEL_OFS(FSEL_OFS), .BLK_OFS(BLK_OFS), .TRIG_OFS(TRIG_OFS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .busy_i(busy_o), .done_i(done),
    .mode_o(upd_mode_o), .fmode_o(fmode), .blk_o(blk), .start_o(start)
  );

  fus_geom #(
    .BLK_W(BLK_W), .LEN_W(LEN_W), .FL_AW(FL_AW), .BLK_A(BLK_A), .BLK_B(BLK_B)
  ) u_geom (
    .dev_i(fmode.dev), .blk_i(blk), .len_o(len), .base_o(base)
  );

  fus_stream #(
    .LEN_W(LEN_W), .FL_AW(FL_AW), .BUF_AW(BUF_AW), .STAGE_BASE(STAGE_BASE)
  ) u_stream (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .prog_i(fmode.prog),
    .dev_i(fmode.dev), .len_i(len), .base_i(base), .busy_o(busy_o),
    .done_o(done), .irq_o(irq_o), .buf_addr_o(buf_addr_o),
    .buf_rdata_i(buf_rdata_i), .fl_valid_o(fl_valid_o), .fl_ready_i(fl_ready_i),
    .fl_prog_o(fl_prog_o), .fl_dev_o(fl_dev_o), .fl_addr_o(fl_addr_o),
    .fl_data_o(fl_data_o)
  );

  // R3
  start_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(upd_mode_o));
endmodule

// File: tb/flash_upd_seq_test.sv
module flash_upd_seq_test;
  localparam int BLK_A = 4224;
  localparam int BLK_B = 4096;
  localparam int STAGE = 24576;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [6:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic        busy_o, irq_o, upd_mode_o;
  logic [14:0] buf_addr_o;
  logic [7:0]  buf_rdata_i;
  logic        fl_valid_o;
  logic        fl_ready_i = 1'b0;
  logic        fl_prog_o, fl_dev_o;
  logic [31:0] fl_addr_o;
  logic [7:0]  fl_data_o;

  always #2.5 clk_i = ~clk_i;

  flash_upd_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .busy_o(busy_o), .irq_o(irq_o),
    .upd_mode_o(upd_mode_o), .buf_addr_o(buf_addr_o), .buf_rdata_i(buf_rdata_i),
    .fl_valid_o(fl_valid_o), .fl_ready_i(fl_ready_i), .fl_prog_o(fl_prog_o),
    .fl_dev_o(fl_dev_o), .fl_addr_o(fl_addr_o), .fl_data_o(fl_data_o)
  );

  // staging buffer model
  logic [7:0]  mem [BLK_A];
  logic [14:0] midx;
  assign midx = buf_addr_o - 15'(STAGE);
  assign buf_rdata_i = (midx < 15'(BLK_A)) ? mem[midx] : 8'h00;

  int vectors = 0, miscompares = 0;
  int beats = 0, beat_err = 0, hold_err = 0, irq_cnt = 0;
  int first_bad = -1;
  logic        exp_prog = 1'b0, exp_dev = 1'b0;
  logic [31:0] exp_base = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic        stall_prev = 1'b0;
  logic [31:0] prev_addr = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // flash port model and beat monitor, all away from the rising edge
  always @(negedge clk_i) begin
    logic r;
    if (stall_prev && (!fl_valid_o || fl_addr_o != prev_addr)) hold_err++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    r = lfsr[0] | lfsr[3];
    if (fl_valid_o && r) begin
      logic [31:0] ea;
      ea = exp_prog ? exp_base + 32'(beats) : 32'd0;
      if (fl_prog_o != exp_prog || fl_dev_o != exp_dev || fl_addr_o != ea ||
          (exp_prog && fl_data_o != mem[beats])) begin
        beat_err++;
        if (first_bad < 0) first_bad = beats;
      end
      beats++;
    end
    stall_prev = fl_valid_o && !r;
    prev_addr  = fl_addr_o;
    fl_ready_i = r;
    if (irq_o) irq_cnt++;
  end

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < BLK_A; i++) begin
      int j;
      j = i ^ 1; // staged image is halfword-swapped
      mem[i] = 8'((j * 37 + seed) ^ (j >> 5));
    end
  endtask

  task automatic wait_irq(input int n0);
    for (int k = 0; k < 20000 && irq_cnt == n0; k++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk(busy_o == 0 && irq_o == 0, "R1 busy/irq", {busy_o, irq_o}, 0);
    chk(upd_mode_o == 0 && fl_valid_o == 0, "R1 mode/valid", {upd_mode_o, fl_valid_o}, 0);
  endtask

  task automatic t_no_mode();
    int b0;
    b0 = beats;
    wr(7'h58, 16'd1); wr(7'h64, 16'd0); wr(7'h6C, 16'd1);
    repeat (8) @(negedge clk_i);
    chk(busy_o == 0, "R3 busy outside mode", busy_o, 0);
    chk(beats == b0, "R3 beats outside mode", beats - b0, 0);
    wr(7'h6C, 16'd0);
  endtask

  task automatic t_enter();
    wr(7'h5C, 16'd1);
    chk(upd_mode_o == 1, "R2 enter update mode", upd_mode_o, 1);
  endtask

  task automatic t_op(input logic [1:0] fsel, input int blk, input int nbeats,
                      input bit meddle, input string tag);
    int n0;
    exp_prog = fsel[0]; exp_dev = fsel[1];
    exp_base = fsel[0] ? 32'(blk) * 32'(nbeats) : 32'd0;
    beats = 0; beat_err = 0; hold_err = 0; first_bad = -1;
    n0 = irq_cnt;
    wr(7'h58, 16'(fsel)); wr(7'h64, 16'(blk)); wr(7'h6C, 16'd1);
    chk(busy_o == 1, {tag, " R9 busy after trigger"}, busy_o, 1);
    if (meddle) begin
      repeat (100) @(negedge clk_i);
      wr(7'h6C, 16'd0); wr(7'h6C, 16'd1); wr(7'h5C, 16'd0);
      chk(upd_mode_o == 1 && busy_o == 1, {tag, " R11 mode held while busy"},
          upd_mode_o, 1);
    end
    wait_irq(n0);
    chk(irq_cnt == n0 + 1, {tag, " R9 irq pulse"}, irq_cnt - n0, 1);
    chk(busy_o == 0, {tag, " R9 busy low at irq"}, busy_o, 0);
    if (meddle) chk(upd_mode_o == 0, {tag, " R11 mode drops at completion"}, upd_mode_o, 0);
    chk(beats == nbeats, {tag, " R6/R7 beat count"}, beats, nbeats);
    chk(beat_err == 0, {tag, " R5/R7/R8 beat content, first bad beat"}, first_bad, -1);
    chk(hold_err == 0, {tag, " R12 hold under stall"}, hold_err, 0);
    @(negedge clk_i);
    chk(irq_o == 0 && irq_cnt == n0 + 1, {tag, " R9/R10 single irq"}, irq_cnt - n0, 1);
  endtask

  task automatic t_retrigger_held();
    int b0;
    b0 = beats;
    wr(7'h6C, 16'd1); // still 1 from previous op
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0 && beats == b0, "R4 held trigger no restart", beats - b0, 0);
    wr(7'h6C, 16'd0);
  endtask

  task automatic t_after_exit();
    int b0;
    b0 = beats;
    wr(7'h58, 16'd0); wr(7'h6C, 16'd1);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0 && beats == b0, "R3 ignored after deferred exit", beats - b0, 0);
    wr(7'h6C, 16'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog act=1 exp=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_no_mode();
    t_enter();
    t_op(2'd0, 0, 1, 1'b0, "eraseA");
    t_retrigger_held();
    fill(11);
    t_op(2'd1, 3, BLK_A, 1'b0, "progA R13 blk3");
    wr(7'h6C, 16'd0);
    fill(90);
    t_op(2'd3, 5, BLK_B, 1'b1, "progB R10");
    wr(7'h6C, 16'd0);
    t_after_exit();
    t_enter();
    t_op(2'd2, 0, 1, 1'b0, "eraseB");
    wr(7'h6C, 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule